// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the floating-point status and control word of a RISC core and keeps it up to date. Two sources change it. The floating-point datapath sends a result-update strobe with new exception flags, rounding flags and either a result class or a compare outcome. Software sends commands: a field write under an 8-bit field mask, a 4-bit immediate write to one field, a set of one bit, a clear of one bit, and a copy of one field out to the condition register.

The exception bits are sticky. The first summary bit latches whenever any exception bit goes from 0 to 1. The enabled-exception summary and the invalid-operation summary are never stored. They are formed as ORs of the stored bits, so no command can write them. The full 32-bit word can always be read, and a 4-bit read port selects one field.

When a software command and a datapath update arrive in the same cycle, the command is applied and the update is dropped.

Top module: `fpsr_unit`

## Requirements
- R1: After reset every bit of `fpsr_o` is 0.
- R2: A datapath update (`upd_valid`=1 while `cmd_op`=0) ORs `upd_exc[i]` into bit 3+i. The bits are overflow 3, underflow 4, zero-divide 5, inexact 6, signalling-NaN 7, inf-inf 8, inf/inf 9, 0/0 10, inf*0 11 and invalid-compare 12. These bits are never cleared by a datapath update.
- R3: Bit 0 (exception summary) is set when any bit in 3..12 goes from 0 to 1. This applies to a datapath update and also to a command that does not itself write bit 0. A command that writes bit 0 gives it exactly the written value. Setting an exception bit that is already 1 leaves bit 0 unchanged.
- R4: Bit 2 equals the OR of bits 7..12. Bit 1 equals the OR of five terms: bit2&bit24, bit3&bit25, bit4&bit26, bit5&bit27 and bit6&bit28. Writes aimed at bits 1 and 2 have no effect.
- R5: A non-compare update (`upd_cmp`=0) writes three things. `upd_fr` goes to bit 13 and `upd_fi` goes to bit 14. `upd_class[4:0]` goes to bits 15..19, where bit 15 is the class bit and bits 16, 17, 18 and 19 are less, greater, equal and unordered.
- R6: A compare update (`upd_cmp`=1) sets exactly one of bits 16..19, namely bit 16+`upd_cc`, and clears the other three. Bits 13, 14 and 15 keep their values.
- R7: `cmd_op`=1 replaces field k (bits 4k+3..4k) with the same bits of `cmd_data` for every k where `cmd_mask[k]`=1.
- R8: `cmd_op`=2 replaces field `fld_sel` with `cmd_imm`.
- R9: `cmd_op`=3 sets bit `cmd_bit` and `cmd_op`=4 clears bit `cmd_bit`.
- R10: `cmd_op`=5 reads the field `fld_sel` on `rd_field` in that cycle. At the next edge it clears bit 0 and bits 3..12 that lie in that field, and leaves the other bits unchanged.
- R11: Bits 20..23 and 29 always read 0, and writes to them are ignored. Bits 24..28 are the enables and bits 30..31 are the rounding mode. Both are stored as written.
- R12: When a command and a datapath update arrive in the same cycle, only the command takes effect.
- R13: `rd_field` always equals `fpsr_o[4*fld_sel+3 : 4*fld_sel]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Datapath result-update strobe |
| upd_cmp | input | 1 | Update comes from a compare |
| upd_exc | input | 10 | New exception flags (bit i maps to register bit 3+i) |
| upd_fr | input | 1 | Fraction-rounded flag |
| upd_fi | input | 1 | Fraction-inexact flag |
| upd_class | input | 5 | Result class and condition bits for non-compare updates |
| upd_cc | input | 2 | Compare outcome: 0 less, 1 greater, 2 equal, 3 unordered |
| cmd_op | input | 3 | Command: 0 none, 1 masked field write, 2 field immediate, 3 set bit, 4 clear bit, 5 copy field |
| cmd_mask | input | 8 | Field mask for command 1 |
| cmd_data | input | 32 | Data for command 1 |
| cmd_imm | input | 4 | Immediate for command 2 |
| cmd_bit | input | 5 | Bit index for commands 3 and 4 |
| fld_sel | input | 3 | Field index for read, command 2 and command 5 |
| fpsr_o | output | 32 | Full register value including derived bits |
| rd_field | output | 4 | Selected field |

## Verification
The hardest state to reach is one where the exception summary was cleared and then an update arrives whose flags are already set. There the summary must stay 0, even though the exception bits are written again. The stimulus clears bit 0 explicitly between datapath updates and uses repeating flag patterns. A bench-side model tracks the rising edges and is compared against bit 0 every cycle. A second hard case is a command that collides with an update carrying a different flag. The table drives the two together on the same clock edge and expects only the command's effect.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int FPSR_W  = 32;
  localparam int FLD_W   = 4;
  localparam int NUM_FLD = FPSR_W / FLD_W;
  localparam int EXC_N   = 10;
  localparam int EXC_LSB = 3;
  localparam int CLS_W   = 5;

  localparam int B_FX  = 0;
  localparam int B_FEX = 1;
  localparam int B_VX  = 2;
  localparam int B_OX  = 3;
  localparam int B_UX  = 4;
  localparam int B_ZX  = 5;
  localparam int B_XX  = 6;
  localparam int B_INV_LO = 7;
  localparam int B_INV_HI = 12;
  localparam int B_FR  = 13;
  localparam int B_FI  = 14;
  localparam int B_CLS = 15;
  localparam int B_CC  = 16;
  localparam int B_EN  = 24;

  localparam logic [FPSR_W-1:0] EXC_MASK    = ((FPSR_W'(1) << EXC_N) - 1) << EXC_LSB;
  localparam logic [FPSR_W-1:0] STICKY_MASK = EXC_MASK | (FPSR_W'(1) << B_FX);
  localparam logic [FPSR_W-1:0] RSV_MASK    = 32'h00F0_0000 | (FPSR_W'(1) << 29);
  localparam logic [FPSR_W-1:0] DERIV_MASK  = (FPSR_W'(1) << B_FEX) | (FPSR_W'(1) << B_VX);
  localparam logic [FPSR_W-1:0] STORE_MASK  = ~(RSV_MASK | DERIV_MASK);

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_FLDMASK = 3'd1,
    OP_FLDIMM  = 3'd2,
    OP_SETBIT  = 3'd3,
    OP_CLRBIT  = 3'd4,
    OP_COPY    = 3'd5
  } fpsr_op_e;

  function automatic logic fpsr_vx(input logic [FPSR_W-1:0] s);
    return |s[B_INV_HI:B_INV_LO];
  endfunction

  function automatic logic fpsr_fex(input logic [FPSR_W-1:0] s);
    logic [4:0] flags;
    flags = {s[B_XX], s[B_ZX], s[B_UX], s[B_OX], fpsr_vx(s)};
    return |(flags & s[B_EN +: 5]);
  endfunction

  function automatic logic [FPSR_W-1:0] fld_mask(input logic [2:0] idx);
    return FPSR_W'({FLD_W{1'b1}}) << (int'(idx) * FLD_W);
  endfunction

  function automatic logic [FPSR_W-1:0] expand_mask(input logic [NUM_FLD-1:0] m);
    logic [FPSR_W-1:0] r;
    for (int k = 0; k < NUM_FLD; k++) r[k*FLD_W +: FLD_W] = {FLD_W{m[k]}};
    return r;
  endfunction
endpackage

// File: rtl/fpsr_hw_merge.sv
module fpsr_hw_merge
  import fpsr_pkg::*;
(
  input  logic [FPSR_W-1:0] st,
  input  logic              upd_cmp,
  input  logic [EXC_N-1:0]  upd_exc,
  input  logic              upd_fr,
  input  logic              upd_fi,
  input  logic [CLS_W-1:0]  upd_class,
  input  logic [1:0]        upd_cc,
  output logic [FPSR_W-1:0] nxt,
  output logic [EXC_N-1:0]  rise
);
  logic [EXC_N-1:0] old_exc;

  assign old_exc = st[EXC_LSB +: EXC_N];
  assign rise    = upd_exc & ~old_exc;

  always_comb begin
    nxt = st;
    nxt[EXC_LSB +: EXC_N] = old_exc | upd_exc;
    nxt[B_FX] = st[B_FX] | (|rise);
    if (upd_cmp) begin
      nxt[B_CC +: 4] = 4'b0001 << upd_cc;
    end else begin
      nxt[B_FR] = upd_fr;
      nxt[B_FI] = upd_fi;
      nxt[B_CLS +: CLS_W] = upd_class;
    end
    nxt = nxt & STORE_MASK;
  end
endmodule

// File: rtl/fpsr_sw_cmd.sv
module fpsr_sw_cmd
  import fpsr_pkg::*;
(
  input  logic [FPSR_W-1:0]  st,
  input  logic [2:0]         cmd_op,
  input  logic [NUM_FLD-1:0] cmd_mask,
  input  logic [FPSR_W-1:0]  cmd_data,
  input  logic [FLD_W-1:0]   cmd_imm,
  input  logic [4:0]         cmd_bit,
  input  logic [2:0]         fld_sel,
  output logic [FPSR_W-1:0]  nxt,
  output logic               act,
  output logic [FPSR_W-1:0]  clr_mask
);
  fpsr_op_e op;
  logic [FPSR_W-1:0] wm, wv, raw;
  logic rise;

  assign op       = fpsr_op_e'(cmd_op);
  assign clr_mask = fld_mask(fld_sel) & STICKY_MASK;

  always_comb begin
    act = 1'b1;
    wm  = '0;
    wv  = '0;
    case (op)
      OP_FLDMASK: begin wm = expand_mask(cmd_mask); wv = cmd_data; end
      OP_FLDIMM:  begin wm = fld_mask(fld_sel); wv = FPSR_W'(cmd_imm) << (int'(fld_sel) * FLD_W); end
      OP_SETBIT:  begin wm = FPSR_W'(1) << cmd_bit; wv = '1; end
      OP_CLRBIT:  begin wm = FPSR_W'(1) << cmd_bit; wv = '0; end
      OP_COPY:    begin wm = clr_mask; wv = '0; end
      default:    act = 1'b0;
    endcase
    raw  = ((st & ~wm) | (wv & wm)) & STORE_MASK;
    rise = |(raw & ~st & EXC_MASK);
    nxt  = raw;
    nxt[B_FX] = wm[B_FX] ? raw[B_FX] : (st[B_FX] | rise);
  end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_valid,
  input  logic        upd_cmp,
  input  logic [9:0]  upd_exc,
  input  logic        upd_fr,
  input  logic        upd_fi,
  input  logic [4:0]  upd_class,
  input  logic [1:0]  upd_cc,
  input  logic [2:0]  cmd_op,
  input  logic [7:0]  cmd_mask,
  input  logic [31:0] cmd_data,
  input  logic [3:0]  cmd_imm,
  input  logic [4:0]  cmd_bit,
  input  logic [2:0]  fld_sel,
  output logic [31:0] fpsr_o,
  output logic [3:0]  rd_field
);
  logic [FPSR_W-1:0] st, hw_next, sw_next, sw_clr, st_next;
  logic [EXC_N-1:0]  hw_rise;
  logic              sw_act, hw_take;

  fpsr_hw_merge u_hw (
    .st(st), .upd_cmp(upd_cmp), .upd_exc(upd_exc), .upd_fr(upd_fr),
    .upd_fi(upd_fi), .upd_class(upd_class), .upd_cc(upd_cc),
    .nxt(hw_next), .rise(hw_rise)
  );

  fpsr_sw_cmd u_sw (
    .st(st), .cmd_op(cmd_op), .cmd_mask(cmd_mask), .cmd_data(cmd_data),
    .cmd_imm(cmd_imm), .cmd_bit(cmd_bit), .fld_sel(fld_sel),
    .nxt(sw_next), .act(sw_act), .clr_mask(sw_clr)
  );

  // software command wins any collision with a datapath update
  assign hw_take = upd_valid && !sw_act;

  always_comb begin
    if (sw_act)       st_next = sw_next;
    else if (hw_take) st_next = hw_next;
    else              st_next = st;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else        st <= st_next & STORE_MASK;
  end

  always_comb begin
    fpsr_o         = st;
    fpsr_o[B_VX]   = fpsr_vx(st);
    fpsr_o[B_FEX]  = fpsr_fex(st);
  end

  assign rd_field = fpsr_o[int'(fld_sel)*FLD_W +: FLD_W];

  p_sticky_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_take |=> ((st & EXC_MASK) & $past(st & EXC_MASK)) == $past(st & EXC_MASK));

  p_fx_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_take && |hw_rise) |=> fpsr_o[B_FX]);

  p_cmp_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_take && upd_cmp) |=> $countones(fpsr_o[B_CC +: 4]) == 1);

  p_copy_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_COPY) |=> (fpsr_o & $past(sw_clr)) == '0);

  p_sw_priority_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_CLRBIT && upd_valid) |=> !st[$past(cmd_bit)]);
endmodule

// File: tb/fpsr_unit_bench.sv
`timescale 1ns/1ps
module fpsr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_valid, upd_cmp, upd_fr, upd_fi;
  logic [9:0]  upd_exc;
  logic [4:0]  upd_class;
  logic [1:0]  upd_cc;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_mask;
  logic [31:0] cmd_data;
  logic [3:0]  cmd_imm;
  logic [4:0]  cmd_bit;
  logic [2:0]  fld_sel;
  logic [31:0] fpsr_o;
  logic [3:0]  rd_field;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fpsr_unit u_fpsr_unit (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_cmp(upd_cmp),
    .upd_exc(upd_exc), .upd_fr(upd_fr), .upd_fi(upd_fi), .upd_class(upd_class),
    .upd_cc(upd_cc), .cmd_op(cmd_op), .cmd_mask(cmd_mask), .cmd_data(cmd_data),
    .cmd_imm(cmd_imm), .cmd_bit(cmd_bit), .fld_sel(fld_sel),
    .fpsr_o(fpsr_o), .rd_field(rd_field)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  mask;
    logic [31:0] data;
    logic [3:0]  imm;
    logic [4:0]  bitn;
    logic [2:0]  fld;
    logic        uv;
    logic        cmp;
    logic [9:0]  exc;
    logic        fr;
    logic        fi;
    logic [4:0]  cls;
    logic [1:0]  cc;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R2 R3 R5: overflow, FR, greater
    '{3'd0, 8'h00, 32'h0, 4'h0, 5'd0, 3'd0, 1'b1, 1'b0, 10'h001, 1'b1, 1'b0, 5'b00100, 2'd0, 32'h0002_2009},
    // R7 R11 R4: enables and rounding, bit 29 dropped, FEX from OX&OE
    '{3'd1, 8'hC0, 32'h3F00_0000, 4'h0, 5'd0, 3'd7, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0, 5'b0, 2'd0, 32'h1F02_200B},
    // R4: set of VX ignored
    '{3'd3, 8'h00, 32'h0, 4'h0, 5'd2, 3'd0, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0, 5'b0, 2'd0, 32'h1F02_200B},
    // R4: clear of FEX ignored
    '{3'd4, 8'h00, 32'h0, 4'h0, 5'd1, 3'd0, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0, 5'b0, 2'd0, 32'h1F02_200B},
    // R9 R3: explicit clear of FX
    '{3'd4, 8'h00, 32'h0, 4'h0, 5'd0, 3'd0, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0, 5'b0, 2'd0, 32'h1F02_200A},
    // R6: compare equal, invalid compare raises FX and VX
    '{3'd0, 8'h00, 32'h0, 4'h0, 5'd0, 3'd4, 1'b1, 1'b1, 10'h200, 1'b0, 1'b0, 5'b0, 2'd2, 32'h1F04_300F},
    // R9: clear FX again
    '{3'd4, 8'h00, 32'h0, 4'h0, 5'd0, 3'd0, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0, 5'b0, 2'd0, 32'h1F04_300E},
    // R3 R5: overflow already set, no FX; FR/FI/class overwritten
    '{3'd0, 8'h00, 32'h0, 4'h0, 5'd0, 3'd3, 1'b1, 1'b0, 10'h001, 1'b0, 1'b1, 5'b10001, 2'd0, 32'h1F08_D00E},
    // R10: copy field 0
    '{3'd5, 8'h00, 32'h0, 4'h0, 5'd0, 3'd0, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0, 5'b0, 2'd0, 32'h1F08_D006},
    // R10: copy field 3 clears only invalid compare
    '{3'd5, 8'h00, 32'h0, 4'h0, 5'd0, 3'd3, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0, 5'b0, 2'd0, 32'h1F08_C000},
    // R8 R3: immediate sets zero-divide, FX rises
    '{3'd2, 8'h00, 32'h0, 4'h2, 5'd0, 3'd1, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0, 5'b0, 2'd0, 32'h1F08_C023},
    // R12: set underflow collides with SNaN update; update dropped
    '{3'd3, 8'h00, 32'h0, 4'h0, 5'd4, 3'd1, 1'b1, 1'b0, 10'h010, 1'b1, 1'b1, 5'b11111, 2'd0, 32'h1F08_C033},
    // R7: field 0 write, FX explicit 0, derived bits ignored
    '{3'd1, 8'h01, 32'h0000_0006, 4'h0, 5'd0, 3'd0, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0, 5'b0, 2'd0, 32'h1F08_C032}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    upd_valid = 0; upd_cmp = 0; upd_exc = '0; upd_fr = 0; upd_fi = 0;
    upd_class = '0; upd_cc = '0; cmd_op = '0; cmd_mask = '0; cmd_data = '0;
    cmd_imm = '0; cmd_bit = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] m, input logic [31:0] d,
                     input logic [4:0] b, input logic [2:0] f);
    idle();
    cmd_op = op; cmd_mask = m; cmd_data = d; cmd_bit = b; fld_sel = f;
    tick();
    idle();
  endtask

  task automatic hw(input logic cmp, input logic [9:0] e, input logic [1:0] c);
    idle();
    upd_valid = 1; upd_cmp = cmp; upd_exc = e; upd_cc = c;
    tick();
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    fld_sel = '0;
    do_reset();
    check("R1 reset", fpsr_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      idle();
      cmd_op = VECS[i].op; cmd_mask = VECS[i].mask; cmd_data = VECS[i].data;
      cmd_imm = VECS[i].imm; cmd_bit = VECS[i].bitn; fld_sel = VECS[i].fld;
      upd_valid = VECS[i].uv; upd_cmp = VECS[i].cmp; upd_exc = VECS[i].exc;
      upd_fr = VECS[i].fr; upd_fi = VECS[i].fi; upd_class = VECS[i].cls;
      upd_cc = VECS[i].cc;
      tick();
      check($sformatf("table %0d", i), fpsr_o, VECS[i].exp);
      check($sformatf("R13 field %0d", i), {28'h0, rd_field},
            {28'h0, 4'(VECS[i].exp >> (4 * VECS[i].fld))});
    end
    idle();

    // R11 R7: write all ones to every field
    do_reset();
    check("R1 reset again", fpsr_o, 32'h0);
    cmd(3'd1, 8'hFF, 32'hFFFF_FFFF, 5'd0, 3'd0);
    check("R11 reserved", fpsr_o, 32'hDF0F_FFFF);
    for (int f = 0; f < 8; f++) begin
      fld_sel = 3'(f);
      #0.1;
      check("R13 sweep", {28'h0, rd_field}, {28'h0, 4'(32'hDF0F_FFFF >> (4 * f))});
    end
    // R10: copy fields 1, 2 and 0 in turn
    cmd(3'd5, 8'h00, 32'h0, 5'd0, 3'd1);
    check("R10 copy f1", fpsr_o, 32'hDF0F_FF0F);
    cmd(3'd5, 8'h00, 32'h0, 5'd0, 3'd2);
    check("R10 copy f2", fpsr_o, 32'hDF0F_F00F);
    cmd(3'd5, 8'h00, 32'h0, 5'd0, 3'd0);
    check("R10 copy f0", fpsr_o, 32'hDF0F_F006);

    // R6: every compare code
    do_reset();
    for (int c = 0; c < 4; c++) begin
      hw(1'b1, 10'h000, 2'(c));
      check("R6 compare", {28'h0, fpsr_o[19:16]}, 32'(1 << c));
    end

    // R2 R3: FX against a bench model over a flag sequence
    do_reset();
    begin
      logic [9:0] m_exc;
      logic       m_fx;
      m_exc = '0; m_fx = 1'b0;
      for (int i = 0; i < 12; i++) begin
        logic [9:0] pat;
        if (i % 3 == 0) begin
          cmd(3'd4, 8'h00, 32'h0, 5'd0, 3'd0);
          m_fx = 1'b0;
        end
        pat = 10'((i * i * 13 + 5) % 1024) & 10'h0A5;
        if ((pat & ~m_exc) != 0) m_fx = 1'b1;
        m_exc = m_exc | pat;
        hw(1'b0, pat, 2'd0);
        check("R3 fx model", {31'h0, fpsr_o[0]}, {31'h0, m_fx});
        check("R2 sticky model", {22'h0, fpsr_o[12:3]}, {22'h0, m_exc});
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule